// File: doc/BRIEF.md
# Dual-Lane Latched Parity Transceiver

This block passes byte-wide data between two buses, called side A and side B, over two identical lanes. Each lane carries eight data bits and one parity bit. On each side, a level-sensitive latch captures what arrives from that side's bus. The word driven onto the opposite bus always comes from that latch.

For the outgoing parity bit there are two choices:
- It can be computed from the latched data byte.
- It can be forwarded exactly as received.

A polarity input selects even or odd parity for both the generated bit and the checker.

Each latch has its own parity checker with an active-low fault output. The checkers keep running when neither bus is driven. A checker is silenced only when its side is being driven by the block while its latch is closed.

Every bus is modelled as a separate input word, output word and drive-enable flag, with no tristate pins. Both lanes share all control inputs.

Top module: `ptx_lane_pair`

## Requirements
- R1: The block has LANES identical lanes, two by default. Each lane has BYTE_W data bits, eight by default, plus one parity bit on each side. All lanes share the gate, mode, polarity and drive inputs.
- R2: The side-A latch follows `a_dat_i`/`a_par_i` while `a_gate` is 1 and holds its last value while `a_gate` is 0. The side-B latch behaves the same way with `b_gate`. `b_dat_o` always shows the side-A latch data, and `a_dat_o` always shows the side-B latch data.
- R3: When `par_pass` is 0, the parity output on each bus is generated so that this count is even when `par_odd` is 0 and odd when `par_odd` is 1: the ones in the source latch's data byte plus the generated bit.
- R4: When `par_pass` is 1, the parity output on each bus equals the parity bit held in the source latch.
- R5: While a latch is closed, its generated parity is computed from the held byte, and changes on the live input bus have no effect on it.
- R6: `a_fault_n[l]` is 0 exactly when this count does not match the selected polarity: the ones in lane l's side-A latch (8 data bits plus the parity bit). Here even means 0 and odd means 1. `b_fault_n` behaves the same way for side B. The fault outputs stay valid when neither bus is driven.
- R7: While `b_drive_n` is 0 and `b_gate` is 0, every `b_fault_n` bit is held at 1. While `a_drive_n` is 0 and `a_gate` is 0, every `a_fault_n` bit is held at 1.
- R8: Drive enables are active-low. `a_drv_o` is 1 exactly when `a_drive_n` is 0, and `b_drv_o` is 1 exactly when `b_drive_n` is 0. Driving both at once is not permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_dat_i | input | LANES*BYTE_W | Data arriving from bus A, lane l at [l*BYTE_W +: BYTE_W] |
| a_par_i | input | LANES | Parity arriving from bus A, one bit per lane |
| b_dat_i | input | LANES*BYTE_W | Data arriving from bus B |
| b_par_i | input | LANES | Parity arriving from bus B |
| a_gate | input | 1 | Side-A latch transparent when 1 |
| b_gate | input | 1 | Side-B latch transparent when 1 |
| par_pass | input | 1 | 0 generates parity, 1 forwards the received parity |
| par_odd | input | 1 | 0 even parity, 1 odd parity |
| a_drive_n | input | 1 | Active-low request to drive bus A |
| b_drive_n | input | 1 | Active-low request to drive bus B |
| a_dat_o | output | LANES*BYTE_W | Data for bus A, from the side-B latch |
| a_par_o | output | LANES | Parity for bus A |
| a_drv_o | output | 1 | Bus A output enable |
| b_dat_o | output | LANES*BYTE_W | Data for bus B, from the side-A latch |
| b_par_o | output | LANES | Parity for bus B |
| b_drv_o | output | 1 | Bus B output enable |
| a_fault_n | output | LANES | Active-low parity fault of each side-A latch |
| b_fault_n | output | LANES | Active-low parity fault of each side-B latch |

## Verification
The hardest case to reach is a closed latch that holds a byte whose parity differs from the byte now on the live bus. Generation and fault checking must then follow the held value, and the blocking of the receive-side fault depends on both the gate and the drive direction. The stimulus walks every legal combination of mode, polarity, both gates and the three permitted drive settings. For each combination it applies several fresh random data words, so a closed latch sees changing live inputs while a behavioural model tracks what each latch last captured. All-zero and all-one bytes with deliberately wrong parity bits are mixed in, so that the fault outputs toggle in both polarities.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
   localparam int unsigned PTX_DEF_LANES  = 2;
   localparam int unsigned PTX_DEF_BYTE_W = 8;

   typedef enum logic {
      PAR_SRC_GEN  = 1'b0,
      PAR_SRC_PASS = 1'b1
   } par_src_e;
endpackage

// File: rtl/ptx_side_latch.sv
module ptx_side_latch #(
   parameter int unsigned W = 9
) (
   input  logic         gate,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 2) begin : g_bad_w
         $error("ptx_side_latch: W must hold data plus parity");
      end
   endgenerate

   always_latch begin
      if (gate) q <= d;
   end
endmodule

// File: rtl/ptx_par_unit.sv
module ptx_par_unit #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] dat,
   input  logic              par,
   input  logic              odd,
   input  logic              pass,
   output logic              par_out,
   output logic              fault_n
);
   import ptx_pkg::*;

   logic     byte_x;
   par_src_e src;

   always_comb begin
      byte_x  = ^dat;
      src     = par_src_e'(pass);
      par_out = (src == PAR_SRC_PASS) ? par : (byte_x ^ odd);
      fault_n = ((byte_x ^ par) == odd);
   end
endmodule

// File: rtl/ptx_lane.sv
module ptx_lane #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] a_d,
   input  logic              a_p,
   input  logic [BYTE_W-1:0] b_d,
   input  logic              b_p,
   input  logic              gate_a,
   input  logic              gate_b,
   input  logic              pass,
   input  logic              odd,
   input  logic              drv_a_n,
   input  logic              drv_b_n,
   output logic [BYTE_W-1:0] to_a_d,
   output logic              to_a_p,
   output logic [BYTE_W-1:0] to_b_d,
   output logic              to_b_p,
   output logic              fault_a_n,
   output logic              fault_b_n
);
   localparam int unsigned WORD_W = BYTE_W + 1;

   logic [WORD_W-1:0] hold_a, hold_b;
   logic              raw_a_n, raw_b_n;

   ptx_side_latch #(.W(WORD_W)) u_lat_a (
      .gate (gate_a),
      .d    ({a_p, a_d}),
      .q    (hold_a)
   );

   ptx_side_latch #(.W(WORD_W)) u_lat_b (
      .gate (gate_b),
      .d    ({b_p, b_d}),
      .q    (hold_b)
   );

   ptx_par_unit #(.BYTE_W(BYTE_W)) u_par_a (
      .dat     (hold_a[BYTE_W-1:0]),
      .par     (hold_a[BYTE_W]),
      .odd     (odd),
      .pass    (pass),
      .par_out (to_b_p),
      .fault_n (raw_a_n)
   );

   ptx_par_unit #(.BYTE_W(BYTE_W)) u_par_b (
      .dat     (hold_b[BYTE_W-1:0]),
      .par     (hold_b[BYTE_W]),
      .odd     (odd),
      .pass    (pass),
      .par_out (to_a_p),
      .fault_n (raw_b_n)
   );

   always_comb begin
      to_b_d    = hold_a[BYTE_W-1:0];
      to_a_d    = hold_b[BYTE_W-1:0];
      fault_a_n = raw_a_n | (~drv_a_n & ~gate_a);
      fault_b_n = raw_b_n | (~drv_b_n & ~gate_b);
   end
endmodule

// File: rtl/ptx_lane_pair.sv
module ptx_lane_pair #(
   parameter int unsigned LANES  = ptx_pkg::PTX_DEF_LANES,
   parameter int unsigned BYTE_W = ptx_pkg::PTX_DEF_BYTE_W
) (
   input  logic [LANES*BYTE_W-1:0] a_dat_i,
   input  logic [LANES-1:0]        a_par_i,
   input  logic [LANES*BYTE_W-1:0] b_dat_i,
   input  logic [LANES-1:0]        b_par_i,
   input  logic                    a_gate,
   input  logic                    b_gate,
   input  logic                    par_pass,
   input  logic                    par_odd,
   input  logic                    a_drive_n,
   input  logic                    b_drive_n,
   output logic [LANES*BYTE_W-1:0] a_dat_o,
   output logic [LANES-1:0]        a_par_o,
   output logic                    a_drv_o,
   output logic [LANES*BYTE_W-1:0] b_dat_o,
   output logic [LANES-1:0]        b_par_o,
   output logic                    b_drv_o,
   output logic [LANES-1:0]        a_fault_n,
   output logic [LANES-1:0]        b_fault_n
);
   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("ptx_lane_pair: LANES must be at least 1");
      end
      if (BYTE_W < 1) begin : g_bad_byte
         $error("ptx_lane_pair: BYTE_W must be at least 1");
      end
   endgenerate

   assign a_drv_o = ~a_drive_n;
   assign b_drv_o = ~b_drive_n;

   // R1: one lane instance per lane, all sharing the control inputs
   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         ptx_lane #(.BYTE_W(BYTE_W)) u_lane (
            .a_d       (a_dat_i[l*BYTE_W +: BYTE_W]),
            .a_p       (a_par_i[l]),
            .b_d       (b_dat_i[l*BYTE_W +: BYTE_W]),
            .b_p       (b_par_i[l]),
            .gate_a    (a_gate),
            .gate_b    (b_gate),
            .pass      (par_pass),
            .odd       (par_odd),
            .drv_a_n   (a_drive_n),
            .drv_b_n   (b_drive_n),
            .to_a_d    (a_dat_o[l*BYTE_W +: BYTE_W]),
            .to_a_p    (a_par_o[l]),
            .to_b_d    (b_dat_o[l*BYTE_W +: BYTE_W]),
            .to_b_p    (b_par_o[l]),
            .fault_a_n (a_fault_n[l]),
            .fault_b_n (b_fault_n[l])
         );
      end
   endgenerate
endmodule

// File: rtl/ptx_lane_pair_chk.sv
module ptx_lane_pair_chk #(
   parameter int unsigned LANES  = 2,
   parameter int unsigned BYTE_W = 8
) (
   input logic [LANES*BYTE_W-1:0] a_dat_i,
   input logic [LANES-1:0]        a_par_i,
   input logic [LANES*BYTE_W-1:0] b_dat_i,
   input logic [LANES-1:0]        b_par_i,
   input logic                    a_gate,
   input logic                    b_gate,
   input logic                    par_pass,
   input logic                    par_odd,
   input logic                    a_drive_n,
   input logic                    b_drive_n,
   input logic [LANES*BYTE_W-1:0] a_dat_o,
   input logic [LANES-1:0]        a_par_o,
   input logic [LANES*BYTE_W-1:0] b_dat_o,
   input logic [LANES-1:0]        b_par_o,
   input logic [LANES-1:0]        a_fault_n,
   input logic [LANES-1:0]        b_fault_n
);
   always_comb begin
      if (!$isunknown({a_drive_n, b_drive_n, a_gate, b_gate, par_pass, par_odd})) begin
         a_r8_single_driver: assert (a_drive_n || b_drive_n)
            else $error("both buses driven");
         for (int l = 0; l < LANES; l++) begin
            if (a_gate) begin
               a_r2_open_follows: assert (b_dat_o[l*BYTE_W +: BYTE_W] == a_dat_i[l*BYTE_W +: BYTE_W])
                  else $error("open latch A not transparent");
               if (par_pass) begin
                  a_r4_forward: assert (b_par_o[l] == a_par_i[l])
                     else $error("parity not forwarded");
               end else begin
                  a_r3_generate: assert ((^{a_dat_i[l*BYTE_W +: BYTE_W], b_par_o[l]}) == par_odd)
                     else $error("generated parity wrong");
               end
            end
            if (b_gate) begin
               a_r6_fault_b: assert (b_fault_n[l] == ((^{b_dat_i[l*BYTE_W +: BYTE_W], b_par_i[l]}) == par_odd))
                  else $error("side B fault output wrong");
            end
            if (!b_drive_n && !b_gate) begin
               a_r7_block_b: assert (b_fault_n[l])
                  else $error("blocked fault B asserted");
            end
            if (!a_drive_n && !a_gate) begin
               a_r7_block_a: assert (a_fault_n[l])
                  else $error("blocked fault A asserted");
            end
         end
      end
   end
endmodule

bind ptx_lane_pair ptx_lane_pair_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (
   .a_dat_i   (a_dat_i),
   .a_par_i   (a_par_i),
   .b_dat_i   (b_dat_i),
   .b_par_i   (b_par_i),
   .a_gate    (a_gate),
   .b_gate    (b_gate),
   .par_pass  (par_pass),
   .par_odd   (par_odd),
   .a_drive_n (a_drive_n),
   .b_drive_n (b_drive_n),
   .a_dat_o   (a_dat_o),
   .a_par_o   (a_par_o),
   .b_dat_o   (b_dat_o),
   .b_par_o   (b_par_o),
   .a_fault_n (a_fault_n),
   .b_fault_n (b_fault_n)
);

// File: tb/test_ptx_lane_pair.sv
`timescale 1ns/1ps
module test_ptx_lane_pair;
   localparam int LANES  = 2;
   localparam int BYTE_W = 8;
   localparam int DW     = LANES*BYTE_W;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [DW-1:0]    a_dat_i = '0, b_dat_i = '0;
   logic [LANES-1:0] a_par_i = '0, b_par_i = '0;
   logic a_gate = 1'b0, b_gate = 1'b0, par_pass = 1'b0, par_odd = 1'b0;
   logic a_drive_n = 1'b1, b_drive_n = 1'b1;
   logic [DW-1:0]    a_dat_o, b_dat_o;
   logic [LANES-1:0] a_par_o, b_par_o, a_fault_n, b_fault_n;
   logic a_drv_o, b_drv_o;

   ptx_lane_pair #(.LANES(LANES), .BYTE_W(BYTE_W)) i_ptx_lane_pair (
      .a_dat_i(a_dat_i), .a_par_i(a_par_i), .b_dat_i(b_dat_i), .b_par_i(b_par_i),
      .a_gate(a_gate), .b_gate(b_gate), .par_pass(par_pass), .par_odd(par_odd),
      .a_drive_n(a_drive_n), .b_drive_n(b_drive_n),
      .a_dat_o(a_dat_o), .a_par_o(a_par_o), .a_drv_o(a_drv_o),
      .b_dat_o(b_dat_o), .b_par_o(b_par_o), .b_drv_o(b_drv_o),
      .a_fault_n(a_fault_n), .b_fault_n(b_fault_n)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   int ma_d[LANES], ma_p[LANES], mb_d[LANES], mb_p[LANES];

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int gen_par(int d, int odd);
      return ($countones(d[BYTE_W-1:0]) + odd) % 2;
   endfunction

   function automatic int fault_val(int d, int p, int odd);
      return (($countones(d[BYTE_W-1:0]) + p) % 2 == odd) ? 1 : 0;
   endfunction

   task automatic compare();
      int pa = par_pass, od = par_odd;
      chk("R8 a_drv_o", a_drv_o, (a_drive_n == 0));
      chk("R8 b_drv_o", b_drv_o, (b_drive_n == 0));
      for (int l = 0; l < LANES; l++) begin
         chk("R2 b_dat_o", b_dat_o[l*BYTE_W +: BYTE_W], ma_d[l]);
         chk("R2 a_dat_o", a_dat_o[l*BYTE_W +: BYTE_W], mb_d[l]);
         if (pa) begin
            chk("R4 b_par_o", b_par_o[l], ma_p[l]);
            chk("R4 a_par_o", a_par_o[l], mb_p[l]);
         end else if (!a_gate || !b_gate) begin
            chk("R5 b_par_o", b_par_o[l], gen_par(ma_d[l], od));
            chk("R5 a_par_o", a_par_o[l], gen_par(mb_d[l], od));
         end else begin
            chk("R3 b_par_o", b_par_o[l], gen_par(ma_d[l], od));
            chk("R3 a_par_o", a_par_o[l], gen_par(mb_d[l], od));
         end
         if (!a_drive_n && !a_gate) chk("R7 a_fault_n", a_fault_n[l], 1);
         else chk("R6 a_fault_n", a_fault_n[l], fault_val(ma_d[l], ma_p[l], od));
         if (!b_drive_n && !b_gate) chk("R7 b_fault_n", b_fault_n[l], 1);
         else chk("R6 b_fault_n", b_fault_n[l], fault_val(mb_d[l], mb_p[l], od));
      end
   endtask

   task automatic step(int ga, int gb, int pa, int od, int oa, int ob, int kind);
      @(negedge clk);
      a_gate = ga[0]; b_gate = gb[0]; par_pass = pa[0]; par_odd = od[0];
      a_drive_n = oa[0]; b_drive_n = ob[0];
      for (int l = 0; l < LANES; l++) begin
         int ad, bd;
         ad = (kind == 0) ? 0 : (kind == 1) ? 255 : int'($urandom_range(0, 255));
         bd = (kind == 0) ? 255 : (kind == 1) ? 0 : int'($urandom_range(0, 255));
         a_dat_i[l*BYTE_W +: BYTE_W] = ad[BYTE_W-1:0];
         b_dat_i[l*BYTE_W +: BYTE_W] = bd[BYTE_W-1:0];
         a_par_i[l] = $urandom_range(0, 1);
         b_par_i[l] = $urandom_range(0, 1);
         if (ga != 0) begin ma_d[l] = ad; ma_p[l] = a_par_i[l]; end
         if (gb != 0) begin mb_d[l] = bd; mb_p[l] = b_par_i[l]; end
      end
      #1;
      compare();
   endtask

   initial begin
      // R1: two lanes loaded with distinct values through the shared gates
      step(1, 1, 0, 0, 1, 1, 2);
      chk("R1 lanes independent", (b_dat_o[BYTE_W +: BYTE_W] == ma_d[1]) && (b_dat_o[0 +: BYTE_W] == ma_d[0]), 1);
      for (int pa = 0; pa < 2; pa++)
         for (int od = 0; od < 2; od++)
            for (int g = 0; g < 4; g++)
               for (int oe = 0; oe < 3; oe++)
                  for (int k = 0; k < 4; k++)
                     step(g & 1, g >> 1, pa, od, (oe == 1) ? 0 : 1, (oe == 2) ? 0 : 1, k);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule